// File: doc/BRIEF.md
# Transaction Age Arbiter

This block settles conflicts between a transaction running on the local processor and a conflicting access request from another processor. Each transaction carries an age stamp made of two parts: how many transactions this processor has committed so far, and the processor's identifier. When a conflicting request arrives, the arbiter compares the requester's stamp with the stamp of the local transaction. The older of the two goes ahead and the younger one gives way.

When a local transaction begins, the arbiter captures its stamp and holds it until the transaction commits or aborts. A retried transaction therefore keeps its original priority until a commit moves the counter on. If the requester is the younger party, it is told to stall and retry. If the local transaction is the younger party, a mode input chooses what happens to it. It is either aborted, or it is held while the requester is granted. A request that arrives while no local transaction is running is granted at once. Every request gets exactly one registered verdict, one cycle later.

Top module: `txn_age_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all three verdict outputs are low, the commit counter is 0 and no local transaction is active.
- R2: A request sampled on a clock edge yields exactly one of `grant_o`, `stall_req_o` or `abort_local_o`, high for the single cycle after that edge. A cycle with no request yields none of them.
- R3: A request arriving while no local transaction is active is granted. So is a request arriving in the same cycle as a local commit or a local abort.
- R4: Ages compare lexicographically: a lower commit count is older, and on equal counts a lower processor identifier is older. An exactly equal stamp counts the requester as younger.
- R5: Counts compare with wraparound. The difference requester-count minus local-count is taken modulo 2^CNT_W, and a result with its top bit set (for example 128 when CNT_W is 8) makes the requester older.
- R6: A requester younger than the active local transaction receives `stall_req_o`.
- R7: A requester older than the active local transaction, with `mode_i`=1 (abort mode), causes `abort_local_o`, and the local transaction ends.
- R8: A requester older than the active local transaction, with `mode_i`=0 (stall mode), receives `grant_o`, and the local transaction stays active with its stamp unchanged.
- R9: Each `tx_commit_i` while a transaction is active adds one to the commit counter, which wraps from 2^CNT_W-1 to 0. A commit while idle is ignored.
- R10: The stamp (counter value and `cpu_id_i`) is captured on `tx_begin_i` while idle. A begin pulse or a change of `cpu_id_i` during an active transaction has no effect on the stamp.
- R11: `tx_abort_i` ends the active transaction without changing the commit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id_i | input | ID_W | Identifier of this processor |
| tx_begin_i | input | 1 | Local transaction starts |
| tx_commit_i | input | 1 | Local transaction commits |
| tx_abort_i | input | 1 | Local transaction aborted by another cause |
| mode_i | input | 1 | Fate of a younger local transaction: 0 stall (grant requester), 1 abort |
| req_valid_i | input | 1 | Conflicting request present |
| req_cnt_i | input | CNT_W | Requester's commit count |
| req_id_i | input | ID_W | Requester's processor identifier |
| grant_o | output | 1 | Requester may proceed |
| stall_req_o | output | 1 | Requester must stall and retry |
| abort_local_o | output | 1 | Local transaction is aborted |

## Verification
The bench builds the block with its defaults, an 8-bit commit counter and a 2-bit identifier. With these widths the counter can be driven all the way round its wrap in a few hundred cycles. The 128 and 127 differences that sit on either side of the half-range boundary are also cheap to reach. A 2-bit identifier is enough to produce ties on the count that only the identifier can break, in both directions.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

  typedef enum logic {
    LOSER_STALL = 1'b0,
    LOSER_ABORT = 1'b1
  } loser_mode_e;

  typedef struct packed {
    logic abort_local;
    logic stall_req;
    logic grant;
  } verdict_t;

endpackage

// File: rtl/txarb_stamp_reg.sv
module txarb_stamp_reg #(
  parameter int CNT_W = 8,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             begin_i,
  input  logic             commit_i,
  input  logic             kill_i,
  input  logic [ID_W-1:0]  cpu_id_i,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] stamp_cnt_o,
  output logic [ID_W-1:0]  stamp_id_o
);

  logic             active_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] stamp_cnt_q;
  logic [ID_W-1:0]  stamp_id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      count_q     <= '0;
      stamp_cnt_q <= '0;
      stamp_id_q  <= '0;
    end else if (active_q) begin
      if (commit_i) begin
        active_q <= 1'b0;
        count_q  <= count_q + 1'b1;
      end else if (kill_i) begin
        active_q <= 1'b0;
      end
    end else if (begin_i) begin
      active_q    <= 1'b1;
      stamp_cnt_q <= count_q;
      stamp_id_q  <= cpu_id_i;
    end
  end

  assign active_o    = active_q;
  assign count_o     = count_q;
  assign stamp_cnt_o = stamp_cnt_q;
  assign stamp_id_o  = stamp_id_q;

endmodule

// File: rtl/txarb_age_cmp.sv
module txarb_age_cmp #(
  parameter int CNT_W = 8,
  parameter int ID_W  = 2
) (
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [CNT_W-1:0] loc_cnt_i,
  input  logic [ID_W-1:0]  loc_id_i,
  output logic             req_older_o
);

  localparam int SIGN_BIT = CNT_W - 1;

  logic [CNT_W-1:0] delta;
  logic             cnt_tie;

  always_comb begin
    delta       = req_cnt_i - loc_cnt_i;
    cnt_tie     = (delta == '0);
    req_older_o = delta[SIGN_BIT] | (cnt_tie & (req_id_i < loc_id_i));
  end

endmodule

// File: rtl/txarb_verdict.sv
module txarb_verdict
  import txarb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid_i,
  input  logic        contested_i,
  input  logic        req_older_i,
  input  loser_mode_e mode_i,
  output logic        abort_now_o,
  output verdict_t    verdict_o
);

  verdict_t next_v;
  verdict_t verdict_q;

  always_comb begin
    next_v = '0;
    if (req_valid_i) begin
      if (!contested_i) begin
        next_v.grant = 1'b1;
      end else if (!req_older_i) begin
        next_v.stall_req = 1'b1;
      end else if (mode_i == LOSER_ABORT) begin
        next_v.abort_local = 1'b1;
      end else begin
        next_v.grant = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) verdict_q <= '0;
    else     verdict_q <= next_v;
  end

  assign abort_now_o = next_v.abort_local;
  assign verdict_o   = verdict_q;

endmodule

// File: rtl/txn_age_arbiter.sv
module txn_age_arbiter
  import txarb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  cpu_id_i,
  input  logic             tx_begin_i,
  input  logic             tx_commit_i,
  input  logic             tx_abort_i,
  input  logic             mode_i,
  input  logic             req_valid_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic [ID_W-1:0]  req_id_i,
  output logic             grant_o,
  output logic             stall_req_o,
  output logic             abort_local_o
);

  logic             txn_active;
  logic [CNT_W-1:0] commit_cnt;
  logic [CNT_W-1:0] stamp_cnt;
  logic [ID_W-1:0]  stamp_id;
  logic             req_older;
  logic             abort_now;
  logic             contested;
  verdict_t         verdict;

  txarb_stamp_reg #(.CNT_W(CNT_W), .ID_W(ID_W)) u_stamp (
    .clk         (clk),
    .rst         (rst),
    .begin_i     (tx_begin_i),
    .commit_i    (tx_commit_i),
    .kill_i      (tx_abort_i | abort_now),
    .cpu_id_i    (cpu_id_i),
    .active_o    (txn_active),
    .count_o     (commit_cnt),
    .stamp_cnt_o (stamp_cnt),
    .stamp_id_o  (stamp_id)
  );

  txarb_age_cmp #(.CNT_W(CNT_W), .ID_W(ID_W)) u_cmp (
    .req_cnt_i   (req_cnt_i),
    .req_id_i    (req_id_i),
    .loc_cnt_i   (stamp_cnt),
    .loc_id_i    (stamp_id),
    .req_older_o (req_older)
  );

  assign contested = txn_active & ~tx_commit_i & ~tx_abort_i;

  txarb_verdict u_verdict (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .contested_i (contested),
    .req_older_i (req_older),
    .mode_i      (loser_mode_e'(mode_i)),
    .abort_now_o (abort_now),
    .verdict_o   (verdict)
  );

  assign grant_o       = verdict.grant;
  assign stall_req_o   = verdict.stall_req;
  assign abort_local_o = verdict.abort_local;

endmodule

// File: rtl/txn_age_arbiter_chk.sv
module txn_age_arbiter_chk #(
  parameter int CNT_W = 8,
  parameter int ID_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_commit_i,
  input logic             mode_i,
  input logic             req_valid_i,
  input logic             grant_o,
  input logic             stall_req_o,
  input logic             abort_local_o,
  input logic             txn_active,
  input logic [CNT_W-1:0] commit_cnt,
  input logic [CNT_W-1:0] stamp_cnt,
  input logic [ID_W-1:0]  stamp_id
);

  // R2
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_o, stall_req_o, abort_local_o}));

  // R2
  verdict_per_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> $countones({grant_o, stall_req_o, abort_local_o}) == 1);

  // R2
  silent_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !(grant_o || stall_req_o || abort_local_o));

  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !txn_active) |=> grant_o);

  // R7
  abort_mode_chk: assert property (@(posedge clk) disable iff (rst)
    abort_local_o |-> $past(mode_i));

  // R7
  abort_ends_chk: assert property (@(posedge clk) disable iff (rst)
    abort_local_o |-> !txn_active);

  // R9
  commit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_commit_i && txn_active) |=> commit_cnt == CNT_W'($past(commit_cnt) + 1'b1));

  // R10
  hold_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_active && $past(txn_active)) |-> ($stable(stamp_cnt) && $stable(stamp_id)));

endmodule

bind txn_age_arbiter txn_age_arbiter_chk #(.CNT_W(CNT_W), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_commit_i   (tx_commit_i),
  .mode_i        (mode_i),
  .req_valid_i   (req_valid_i),
  .grant_o       (grant_o),
  .stall_req_o   (stall_req_o),
  .abort_local_o (abort_local_o),
  .txn_active    (txn_active),
  .commit_cnt    (commit_cnt),
  .stamp_cnt     (stamp_cnt),
  .stamp_id      (stamp_id)
);

// File: tb/txn_age_arbiter_tb_top.sv
`timescale 1ns/1ps
module txn_age_arbiter_tb_top;

  localparam int CNT_W = 8;
  localparam int ID_W  = 2;
  localparam int NVEC  = 17;

  // {begin, commit, req, mode, req_cnt[8], req_id[2], expect{abort,stall,grant}}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd5,   2'd0, 3'b001},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   2'd3, 3'b010},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   2'd1, 3'b001},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd1,   2'd0, 3'b010},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,   2'd1, 3'b100},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd3,   2'd0, 3'b001},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,   2'd3, 3'b100},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd129, 2'd0, 3'b001},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd128, 2'd0, 3'b010},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd1,   2'd2, 3'b010},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd0,   2'd0, 3'b000},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,   2'd0, 3'b001}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [ID_W-1:0]  cpu_id_i = 2'd2;
  logic             tx_begin_i = 1'b0, tx_commit_i = 1'b0, tx_abort_i = 1'b0;
  logic             mode_i = 1'b0, req_valid_i = 1'b0;
  logic [CNT_W-1:0] req_cnt_i = '0;
  logic [ID_W-1:0]  req_id_i = '0;
  logic             grant_o, stall_req_o, abort_local_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  txn_age_arbiter #(.CNT_W(CNT_W), .ID_W(ID_W)) dut_i (
    .clk, .rst, .cpu_id_i, .tx_begin_i, .tx_commit_i, .tx_abort_i, .mode_i,
    .req_valid_i, .req_cnt_i, .req_id_i, .grant_o, .stall_req_o, .abort_local_o
  );

  task automatic check(input string tag, input logic [2:0] exp);
    logic [2:0] got;
    got = {abort_local_o, stall_req_o, grant_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {abort,stall,grant} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic b, input logic c, input logic a, input logic r,
                      input logic m, input logic [CNT_W-1:0] rc, input logic [ID_W-1:0] ri);
    tx_begin_i = b; tx_commit_i = c; tx_abort_i = a;
    req_valid_i = r; mode_i = m; req_cnt_i = rc; req_id_i = ri;
    @(posedge clk);
    @(negedge clk);
    tx_begin_i = 0; tx_commit_i = 0; tx_abort_i = 0; req_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", 3'b000);

    // table walk: rows exercise R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][16], VEC[i][15], 1'b0, VEC[i][14], VEC[i][13], VEC[i][12:5], VEC[i][4:3]);
      check($sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8)", i), VEC[i][2:0]);
    end
    // commit count now 2, idle

    // R3: commit in the same cycle as a request
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 1, 1, 8'd0, 2'd0);
    check("R3 request with same-cycle commit", 3'b001);
    // count 3

    // R11: external abort ends transaction, count kept
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd9, 2'd0);
    check("R11 idle after external abort", 3'b001);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd3, 2'd3);
    check("R11 count unchanged (tie, higher id)", 3'b010);
    step(0, 0, 0, 1, 1, 8'd3, 2'd1);
    check("R11 count unchanged (tie, lower id)", 3'b100);

    // R10: stamp held during the transaction
    cpu_id_i = 2'd1;
    step(1, 0, 0, 0, 0, 0, 0);
    cpu_id_i = 2'd3;
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd3, 2'd2);
    check("R10 stamp id kept at begin value", 3'b010);
    step(0, 0, 1, 0, 0, 0, 0);
    cpu_id_i = 2'd2;

    // R9: run the counter up to 255
    for (int k = 3; k < 255; k++) begin
      step(1, 0, 0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0, 0, 0);
    end
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd0, 2'd0);
    check("R5 requester count 0 vs local 255 is younger", 3'b010);
    step(0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd255, 2'd3);
    check("R9 counter wrapped to 0, requester 255 older", 3'b100);

    // R1: reset mid-run clears counter
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    rst = 1'b1;
    step(0, 0, 0, 1, 1, 8'd0, 2'd0);
    check("R1 no verdict under reset", 3'b000);
    rst = 1'b0;
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'd0, 2'd3);
    check("R1 counter back at 0", 3'b010);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R2 no request no verdict", 3'b000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule